// File: doc/BRIEF.md
# Reservation Monitor for Atomic Link/Conditional Memory Access

This block sits between the load/store ports of several requesters and a shared word memory. Each port issues one of four operations. The operations are a plain read, a plain write, a linked read and a conditional write. Each operation carries a base value, a signed 16-bit displacement and write data. The block computes the byte address and serves one access per clock, giving the lowest-numbered requester priority. It returns read data, or a pass/fail code, one cycle after the handshake.

A linked read returns the addressed word and also opens a reservation on that word for the issuing requester. A conditional write commits only when its requester still holds a reservation on the same word. A reservation is lost when any committed write lands on the reserved word, whether it comes from another requester or from the holder itself. A successful conditional write returns 1. A failed one leaves memory alone and returns 0. Software builds swaps, test-and-set and counters on this primitive by retrying until the conditional write returns 1.

Top module: `llsc_monitor`

## Requirements
- R1: The byte address is the base plus the 16-bit displacement sign-extended to 32 bits. Memory bits [IDX_W+1:2] of that address select the word. Reservations compare address bits [31:2].
- R2: An address whose low two bits are not both zero raises rspMisalign and returns data 0. Such an access writes no memory and changes no reservation.
- R3: Operation codes are 0 plain read, 1 plain write, 2 linked read and 3 conditional write. Reads and linked reads return the stored word. A plain write stores its data and returns 0.
- R4: A linked read records a reservation on its word for the issuer. A later linked read by the same requester replaces the earlier reservation.
- R5: A conditional write whose issuer holds a reservation on the same word stores its data and returns 1.
- R6: A conditional write fails if the issuer has no reservation or holds one on a different word. A failed conditional write returns 0 and writes nothing.
- R7: Every conditional write, whether it passes or fails, clears its issuer's reservation.
- R8: Every committed write, plain or conditional, clears every requester's reservation on that word, including the writer's own.
- R9: At most one reqReady bit is set in a cycle. The lowest-indexed valid requester is served and the others stall. Ready is never given without valid.
- R10: rspValid pulses for exactly the served requester in the cycle after its handshake, and is low otherwise.
- R11: After reset no response is pending, no reservation exists and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request valid, one bit per requester |
| reqReady | output | NUM_REQ | Request accepted this cycle |
| reqOp | input | 2*NUM_REQ | Operation code per requester |
| reqBase | input | NUM_REQ*ADDR_W | Base address value per requester |
| reqOffset | input | NUM_REQ*OFF_W | Signed displacement per requester |
| reqWData | input | NUM_REQ*DATA_W | Write data per requester |
| rspValid | output | NUM_REQ | Response strobe per requester |
| rspData | output | NUM_REQ*DATA_W | Read word or pass/fail code per requester |
| rspMisalign | output | NUM_REQ | Response belongs to a misaligned access |

## Verification
The bench builds the block with its defaults: two requesters, 32-bit addresses and data, 16-bit displacements and a 64-word memory. With two requesters, cross-requester reservation loss can be exercised. So can a simultaneous contest for the same word, where the higher-priority conditional write wins and the stalled one then fails. A 64-word memory keeps all test addresses inside a 256-byte window, so no two test addresses alias in the index, and reservation matches can be predicted from the word address alone.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } memOp_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic accept;     // an access is taken this cycle
    logic misalign;   // the taken access is misaligned
    logic memWrite;   // commit write data to memory
    logic retRead;    // response carries the memory word
    logic retStatus;  // response carries the pass/fail code
    logic scPass;     // conditional write passes
  } ctrlStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
`timescale 1ns/1ps
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int WA_W    = 30,
  parameter int GID_W   = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_REQ-1:0]   reqValid,
  input  logic [2*NUM_REQ-1:0] reqOp,
  input  logic [WA_W-1:0]      selWordAddr,
  input  logic                 selMisalign,
  output logic [NUM_REQ-1:0]   reqReady,
  output logic [GID_W-1:0]     grantIdx,
  output ctrlStrobe_t          strobe
);

  logic [1:0]      opArr   [NUM_REQ];
  logic            resValid[NUM_REQ];
  logic [WA_W-1:0] resAddr [NUM_REQ];
  logic            found;
  logic            resHit;
  memOp_e          selOp;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_opUnpack
    assign opArr[i] = reqOp[2*i +: 2];
  end

  // fixed-priority arbiter: lowest index wins
  always_comb begin
    grantIdx = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!found && reqValid[i]) begin
        grantIdx = GID_W'(i);
        found    = 1'b1;
      end
    end
    reqReady = '0;
    if (found) reqReady[grantIdx] = 1'b1;
  end

  assign selOp  = memOp_e'(opArr[grantIdx]);
  assign resHit = resValid[grantIdx] && (resAddr[grantIdx] == selWordAddr);

  always_comb begin
    strobe           = '0;
    strobe.accept    = found;
    strobe.misalign  = selMisalign;
    strobe.scPass    = found && !selMisalign && (selOp == OP_COND) && resHit;
    strobe.memWrite  = found && !selMisalign &&
                       ((selOp == OP_STORE) || strobe.scPass);
    strobe.retRead   = (selOp == OP_LOAD) || (selOp == OP_LINK);
    strobe.retStatus = (selOp == OP_COND);
  end

  // reservation table, one entry per requester
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        resValid[i] <= 1'b0;
        resAddr[i]  <= '0;
      end
    end else if (found && !selMisalign) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        if (strobe.memWrite && resValid[i] && (resAddr[i] == selWordAddr))
          resValid[i] <= 1'b0;
        if (GID_W'(i) == grantIdx) begin
          if (selOp == OP_COND) resValid[i] <= 1'b0;
          if (selOp == OP_LINK) begin
            resValid[i] <= 1'b1;
            resAddr[i]  <= selWordAddr;
          end
        end
      end
    end
  end

endmodule

// File: rtl/llsc_datapath.sv
`timescale 1ns/1ps
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 16,
  parameter int DEPTH   = 64,
  parameter int GID_W   = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ*ADDR_W-1:0] reqBase,
  input  logic [NUM_REQ*OFF_W-1:0]  reqOffset,
  input  logic [NUM_REQ*DATA_W-1:0] reqWData,
  input  logic [GID_W-1:0]          grantIdx,
  input  ctrlStrobe_t               strobe,
  output logic [ADDR_W-3:0]         selWordAddr,
  output logic                      selMisalign,
  output logic [NUM_REQ-1:0]        rspValid,
  output logic [NUM_REQ*DATA_W-1:0] rspData,
  output logic [NUM_REQ-1:0]        rspMisalign
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] effAddr [NUM_REQ];
  logic [DATA_W-1:0] wrWord  [NUM_REQ];
  logic [DATA_W-1:0] rspWord [NUM_REQ];
  logic [DATA_W-1:0] mem     [DEPTH];
  logic [ADDR_W-1:0] selAddr;
  logic [IDX_W-1:0]  memIdx;
  logic [DATA_W-1:0] retWord;

  // address generation per requester
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_agen
    assign effAddr[i] = reqBase[i*ADDR_W +: ADDR_W] +
      {{(ADDR_W-OFF_W){reqOffset[i*OFF_W+OFF_W-1]}}, reqOffset[i*OFF_W +: OFF_W]};
    assign wrWord[i]  = reqWData[i*DATA_W +: DATA_W];
    assign rspData[i*DATA_W +: DATA_W] = rspWord[i];
  end

  assign selAddr     = effAddr[grantIdx];
  assign selWordAddr = selAddr[ADDR_W-1:2];
  assign selMisalign = |selAddr[1:0];
  assign memIdx      = selAddr[IDX_W+1:2];

  always_comb begin
    if (strobe.misalign)       retWord = '0;
    else if (strobe.retStatus) retWord = DATA_W'(strobe.scPass);
    else if (strobe.retRead)   retWord = mem[memIdx];
    else                       retWord = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.memWrite) begin
      mem[memIdx] <= wrWord[grantIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= '0;
      rspMisalign <= '0;
      for (int i = 0; i < NUM_REQ; i++) rspWord[i] <= '0;
    end else begin
      rspValid <= '0;
      if (strobe.accept) begin
        rspValid[grantIdx]    <= 1'b1;
        rspMisalign[grantIdx] <= strobe.misalign;
        rspWord[grantIdx]     <= retWord;
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 16,
  parameter int DEPTH   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  output logic [NUM_REQ-1:0]        reqReady,
  input  logic [2*NUM_REQ-1:0]      reqOp,
  input  logic [NUM_REQ*ADDR_W-1:0] reqBase,
  input  logic [NUM_REQ*OFF_W-1:0]  reqOffset,
  input  logic [NUM_REQ*DATA_W-1:0] reqWData,
  output logic [NUM_REQ-1:0]        rspValid,
  output logic [NUM_REQ*DATA_W-1:0] rspData,
  output logic [NUM_REQ-1:0]        rspMisalign
);

  localparam int GID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int WA_W  = ADDR_W - 2;

  logic [GID_W-1:0] grantIdx;
  logic [WA_W-1:0]  selWordAddr;
  logic             selMisalign;
  ctrlStrobe_t      strobe;

  llsc_ctrl #(.NUM_REQ(NUM_REQ), .WA_W(WA_W), .GID_W(GID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .selWordAddr(selWordAddr), .selMisalign(selMisalign),
    .reqReady(reqReady), .grantIdx(grantIdx), .strobe(strobe)
  );

  llsc_datapath #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .OFF_W(OFF_W), .DEPTH(DEPTH), .GID_W(GID_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqWData(reqWData), .grantIdx(grantIdx), .strobe(strobe),
    .selWordAddr(selWordAddr), .selMisalign(selMisalign),
    .rspValid(rspValid), .rspData(rspData), .rspMisalign(rspMisalign)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk #(
  parameter int NUM_REQ = 2,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_REQ-1:0]        reqValid,
  input logic [NUM_REQ-1:0]        reqReady,
  input logic [2*NUM_REQ-1:0]      reqOp,
  input logic [NUM_REQ-1:0]        rspValid,
  input logic [NUM_REQ*DATA_W-1:0] rspData,
  input logic [NUM_REQ-1:0]        rspMisalign
);

  a_r9_ready_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  a_r9_low_index_wins: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> reqReady[0]);

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_port
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
      reqReady[i] |-> reqValid[i]);

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[i] && reqReady[i]) |=> rspValid[i]);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
      !(reqValid[i] && reqReady[i]) |=> !rspValid[i]);

    a_r2_misalign_zero: assert property (@(posedge clk) disable iff (!rstN)
      (rspValid[i] && rspMisalign[i]) |-> (rspData[i*DATA_W +: DATA_W] == '0));

    a_r5_status_is_bit: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[i] && reqReady[i] && (reqOp[2*i +: 2] == 2'd3))
        |=> (rspData[i*DATA_W+1 +: DATA_W-1] == '0));
  end

endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  reqValid = '0;
  logic [1:0]  reqReady;
  logic [3:0]  reqOp = '0;
  logic [63:0] reqBase = '0;
  logic [31:0] reqOffset = '0;
  logic [63:0] reqWData = '0;
  logic [1:0]  rspValid;
  logic [63:0] rspData;
  logic [1:0]  rspMisalign;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [31:0] mMem [64];
  bit          mResV [2];
  logic [29:0] mResA [2];

  always #2 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqWData(reqWData), .rspValid(rspValid), .rspData(rspData),
    .rspMisalign(rspMisalign)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearWord(input logic [29:0] wa);
    for (int k = 0; k < 2; k++)
      if (mResV[k] && mResA[k] == wa) mResV[k] = 1'b0;
  endtask

  // one clock of stimulus plus model update and comparison
  task automatic step(input bit v0, input logic [1:0] o0, input logic [31:0] b0,
                      input logic [15:0] f0, input logic [31:0] d0,
                      input bit v1, input logic [1:0] o1, input logic [31:0] b1,
                      input logic [15:0] f1, input logic [31:0] d1,
                      input string tag);
    int g;
    logic [1:0]  o;
    logic [31:0] b, d, ea, expData;
    logic [15:0] f;
    logic [1:0]  expReady, expValid;
    bit mis;
    reqValid = {v1, v0}; reqOp = {o1, o0}; reqBase = {b1, b0};
    reqOffset = {f1, f0}; reqWData = {d1, d0};
    #1;
    g = v0 ? 0 : (v1 ? 1 : -1);
    expReady = (g < 0) ? 2'b00 : ((g == 0) ? 2'b01 : 2'b10);
    check(reqReady == expReady, {"R9 ready ", tag}, 64'(reqReady), 64'(expReady));
    expData = '0; mis = 1'b0;
    if (g >= 0) begin
      o = (g == 0) ? o0 : o1; b = (g == 0) ? b0 : b1;
      f = (g == 0) ? f0 : f1; d = (g == 0) ? d0 : d1;
      ea = b + {{16{f[15]}}, f};
      mis = |ea[1:0];
      if (!mis) begin
        case (o)
          LD: expData = mMem[ea[7:2]];
          ST: begin mMem[ea[7:2]] = d; clearWord(ea[31:2]); end
          LL: begin expData = mMem[ea[7:2]]; mResV[g] = 1'b1; mResA[g] = ea[31:2]; end
          default: begin
            if (mResV[g] && mResA[g] == ea[31:2]) begin
              expData = 32'd1; mMem[ea[7:2]] = d; clearWord(ea[31:2]);
            end
            mResV[g] = 1'b0;
          end
        endcase
      end
    end
    @(posedge clk); #1;
    expValid = expReady;
    check(rspValid == expValid, {"R10 valid ", tag}, 64'(rspValid), 64'(expValid));
    if (g >= 0) begin
      check(rspData[g*32 +: 32] == expData, {tag, " data"},
            64'(rspData[g*32 +: 32]), 64'(expData));
      check(rspMisalign[g] == mis, {tag, " misalign"},
            64'(rspMisalign[g]), 64'(mis));
    end
    reqValid = '0;
    @(negedge clk);
  endtask

  task automatic one(input int r, input logic [1:0] o, input logic [31:0] b,
                     input logic [15:0] f, input logic [31:0] d, input string tag);
    if (r == 0) step(1, o, b, f, d, 0, LD, 0, 0, 0, tag);
    else        step(0, LD, 0, 0, 0, 1, o, b, f, d, tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mMem[i] = '0;
    for (int i = 0; i < 2; i++) begin mResV[i] = 1'b0; mResA[i] = '0; end
    repeat (3) @(negedge clk);
    check(rspValid == 2'b00, "R11 no response in reset", 64'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 2'b00, "R11 no response after reset", 64'(rspValid), 0);
    one(0, LD, 32'h0,  16'h0, 0, "R11 memory clear low");
    one(1, LD, 32'hFC, 16'h0, 0, "R11 memory clear high");
    one(1, SC, 32'h0,  16'h0, 32'h55, "R11 no reservation");

    // plain accesses and address arithmetic
    one(0, ST, 32'h10, 16'h0, 32'hA5A5_0001, "R3 store");
    one(0, LD, 32'h8,  16'h8, 0, "R3 load back");
    one(1, LD, 32'h20, 16'hFFF0, 0, "R1 negative offset");
    one(1, LD, 32'hFFFF_FFF0, 16'h0020, 0, "R1 wraparound add");

    // successful pair
    one(0, LL, 32'h10, 16'h0, 0, "R4 link read");
    one(0, SC, 32'h10, 16'h0, 32'hBEEF_0002, "R5 conditional pass");
    one(0, LD, 32'h10, 16'h0, 0, "R5 committed value");
    one(0, SC, 32'h10, 16'h0, 32'h0BAD, "R7 reservation spent");
    one(0, LD, 32'h10, 16'h0, 0, "R7 no write on fail");

    // cross-requester and own-write loss
    one(1, LL, 32'h40, 16'h0, 0, "R4 link read r1");
    one(0, ST, 32'h40, 16'h0, 32'h1111, "R8 other writes");
    one(1, SC, 32'h40, 16'h0, 32'h2222, "R8 lost to other write");
    one(0, LL, 32'h44, 16'h0, 0, "R4 link read r0");
    one(0, ST, 32'h44, 16'h0, 32'h3333, "R8 own write");
    one(0, SC, 32'h44, 16'h0, 32'h4444, "R8 lost to own write");
    one(1, LL, 32'h48, 16'h0, 0, "R4 link read r1b");
    one(0, ST, 32'h4C, 16'h0, 32'h5555, "R8 neighbour write");
    one(1, SC, 32'h48, 16'h0, 32'h6666, "R8 neighbour leaves reservation");

    // replacement and mismatch
    one(0, LL, 32'h50, 16'h0, 0, "R4 first link");
    one(0, LL, 32'h54, 16'h0, 0, "R4 second link");
    one(0, SC, 32'h50, 16'h0, 32'h7777, "R4 replaced reservation fails");
    one(0, LL, 32'h50, 16'h0, 0, "R4 relink");
    one(0, LL, 32'h54, 16'h0, 0, "R4 relink second");
    one(0, SC, 32'h54, 16'h0, 32'h8888, "R4 newest reservation passes");
    one(1, LL, 32'h60, 16'h0, 0, "R6 link");
    one(1, SC, 32'h64, 16'h0, 32'h9999, "R6 different word");
    one(1, LD, 32'h64, 16'h0, 0, "R6 no write");

    // misaligned accesses
    one(0, ST, 32'h60, 16'h2, 32'hDEAD, "R2 misaligned store");
    one(0, LD, 32'h60, 16'h0, 0, "R2 store had no effect");
    one(1, LL, 32'h70, 16'h0, 0, "R2 link");
    one(0, ST, 32'h70, 16'h1, 32'hDEAD, "R2 misaligned write to reserved");
    one(1, SC, 32'h70, 16'h0, 32'hCAFE, "R2 reservation survives");
    one(0, LL, 32'h90, 16'h2, 0, "R2 misaligned link");
    one(0, SC, 32'h90, 16'h0, 32'h1234, "R2 misaligned link reserved nothing");
    one(1, LD, 32'h7F, 16'h0, 0, "R2 misaligned load");

    // contention
    step(1, LL, 32'h84, 16'h0, 0, 1, LL, 32'h84, 16'h0, 0, "R9 both link, r0 served");
    one(1, LL, 32'h84, 16'h0, 0, "R9 stalled r1 link");
    step(1, SC, 32'h84, 16'h0, 32'hAAAA, 1, SC, 32'h84, 16'h0, 32'hBBBB,
         "R9 both conditional, r0 served");
    one(1, SC, 32'h84, 16'h0, 32'hBBBB, "R8 stalled r1 conditional loses");
    one(1, LD, 32'h84, 16'h0, 0, "R8 winner value kept");
    step(0, LD, 0, 0, 0, 0, LD, 0, 0, 0, "R10 idle cycle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule